// File: doc/BRIEF.md
# Selectable-Mode Watchdog Timer

This block counts prescaled clock steps in an 8-bit counter and reacts to the counter wrapping past its top value. The step rate comes from a prescaler with eight taps. The prescaler advances only on cycles where the base-clock enable `tick_in` is high. Tap 0 passes every tick. Taps 1 to 6 divide by 2, 4, 8, 16, 32 and 64. Tap 7 divides by 256.

Three roles share the one counter. As an interval timer, every wrap raises a maskable interrupt request. As a watchdog, a wrap raises either a non-maskable interrupt request or a system reset request that stays high for a fixed number of cycles. Software keeps a watchdog quiet by pulsing `kick` before the counter wraps. Once a watchdog role has been written, the configuration is frozen until the next `rst_n`, so runaway code cannot switch the watchdog off.

Top module: `guard_timer`

## Requirements
- R1: After `rst_n`, `ovf`, `int_req`, `nmi_req` and `rst_req` are low. Until a configuration with `cfg_run`=1 is accepted, nothing counts and `ovf` stays low however many ticks arrive.
- R2: The counter is 8 bits wide, so `ovf` is high for exactly one cycle after 256 prescaler steps. That cycle follows the clock edge on which the 256th step occurs, counting from the edge that accepted the configuration.
- R3: `cfg_tap` sets the number of ticks per step: value 0 gives 1 tick, values k = 1..6 give 2^k ticks, and value 7 gives 256 ticks.
- R4: Only cycles with `tick_in` high advance the prescaler; cycles with `tick_in` low leave it unchanged.
- R5: With `cfg_mode[1]`=0 (interval role; `cfg_mode[0]` has no effect), each wrap raises `int_req` for one cycle, in the same cycle as `ovf`, and `nmi_req` and `rst_req` stay low.
- R6: With `cfg_mode`=2'b10 (watchdog, non-maskable), a wrap raises `nmi_req` for one cycle together with `ovf`, and `int_req` stays low.
- R7: With `cfg_mode`=2'b11 (watchdog, reset), a wrap raises `rst_req` in the same cycle as `ovf`, holds it for exactly RST_HOLD cycles (4 by default), and `int_req` and `nmi_req` stay low.
- R8: While `rst_req` is high, the counter and the prescaler are held at zero. The next wrap comes 256 steps after `rst_req` falls, which is 260 edges after the previous wrap edge at tap 0 with a tick on every cycle.
- R9: A `kick` pulse clears both the counter and the prescaler phase. If it falls on the same edge as a wrapping step, the kick wins and no `ovf` follows.
- R10: An accepted configuration write (`cfg_we` high) also clears the counter and the prescaler, so counting restarts from zero on that edge.
- R11: Once a configuration with `cfg_mode[1]`=1 has been accepted, later writes are ignored until `rst_n`. The role, tap and count are all left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_in | input | 1 | Base-clock enable that advances the prescaler |
| kick | input | 1 | Clear command for the counter and the prescaler |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_run | input | 1 | Count enable written with the configuration |
| cfg_mode | input | 2 | Role: 0x interval, 10 watchdog with NMI, 11 watchdog with reset |
| cfg_tap | input | 3 | Prescaler tap select |
| ovf | output | 1 | One-cycle counter wrap pulse |
| int_req | output | 1 | Maskable interrupt request pulse |
| nmi_req | output | 1 | Non-maskable interrupt request pulse |
| rst_req | output | 1 | System reset request, held RST_HOLD cycles |

## Verification
A table of role, tap and tick-spacing combinations measures the number of edges to the first wrap. A wrong tap exponent, an extra or missing counter bit, or counting on idle ticks each shift that figure by a predictable amount. Each wrap also checks which request line fires, which separates the three roles and shows that the spare role bit is ignored. Directed sequences then cover four cases:
- a kick in mid-count with a divided tap, which exposes a prescaler phase that was not cleared;
- a kick on the very edge of a wrap;
- a rewrite of the configuration mid-count;
- a locked write attempt, which must leave both the role and the running count alone.

The reset-role run measures how long `rst_req` is held, and then how many edges pass before the next wrap, to prove that the counter was frozen.

// File: rtl/guard_timer_pkg.sv
`timescale 1ns/1ps
package guard_timer_pkg;

  localparam int TAP_W = 3;
  localparam int NTAP  = 1 << TAP_W;

  typedef enum logic [1:0] {
    GT_IVL_A  = 2'b00,
    GT_IVL_B  = 2'b01,
    GT_WD_NMI = 2'b10,
    GT_WD_RST = 2'b11
  } gt_mode_e;

  typedef struct packed {
    logic             run;
    gt_mode_e         mode;
    logic [TAP_W-1:0] tap;
  } gt_cfg_t;

  // Tap index to division exponent: the top tap skips one power of two.
  function automatic int gt_tap_shift(input int sel, input int ntap);
    if (sel == ntap - 1) return sel + 1;
    return sel;
  endfunction

endpackage

// File: rtl/guard_cfg.sv
`timescale 1ns/1ps
module guard_cfg
  import guard_timer_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_en,
  input  gt_cfg_t wr_cfg,
  output gt_cfg_t cfg,
  output logic    locked,
  output logic    accept
);

  gt_cfg_t cfg_q, cfg_d;
  logic    lock_q, lock_d;

  always_comb begin
    accept = wr_en & ~lock_q;
    cfg_d  = cfg_q;
    lock_d = lock_q;
    if (accept) begin
      cfg_d  = wr_cfg;
      lock_d = wr_cfg.mode[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{run: 1'b0, mode: GT_IVL_A, tap: '0};
      lock_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      lock_q <= lock_d;
    end
  end

  assign cfg    = cfg_q;
  assign locked = lock_q;

endmodule

// File: rtl/guard_prescaler.sv
`timescale 1ns/1ps
module guard_prescaler
  import guard_timer_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             clear,
  input  logic [TAP_W-1:0] tap,
  output logic             step
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [NTAP-1:0]  tap_hit;
  logic             advance;

  // One full-phase detector per tap.
  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    localparam int               SH  = gt_tap_shift(t, NTAP);
    localparam logic [PRE_W-1:0] MSK = PRE_W'((64'd1 << SH) - 64'd1);
    assign tap_hit[t] = ((pre_q & MSK) == MSK);
  end

  always_comb begin
    advance = run & tick;
    step    = advance & tap_hit[tap];
    if (clear)        pre_d = '0;
    else if (advance) pre_d = pre_q + 1'b1;
    else              pre_d = pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

endmodule

// File: rtl/guard_counter.sv
`timescale 1ns/1ps
module guard_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             live;

  always_comb begin
    live = step & ~clear;
    wrap = live & (&cnt_q);
    if (clear)     cnt_d = '0;
    else if (live) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/guard_action.sv
`timescale 1ns/1ps
module guard_action
  import guard_timer_pkg::*;
#(
  parameter int RST_HOLD = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wrap,
  input  gt_mode_e mode,
  output logic     ovf,
  output logic     int_req,
  output logic     nmi_req,
  output logic     rst_req
);

  localparam int HW = $clog2(RST_HOLD + 1);

  logic          ovf_q, int_q, nmi_q, rst_q;
  logic          ovf_d, int_d, nmi_d, rst_d;
  logic [HW-1:0] hold_q, hold_d;

  always_comb begin
    ovf_d = wrap;
    int_d = wrap & ~mode[1];
    nmi_d = wrap & (mode == GT_WD_NMI);
    if (wrap && mode == GT_WD_RST) hold_d = HW'(RST_HOLD);
    else if (hold_q != '0)         hold_d = hold_q - 1'b1;
    else                           hold_d = '0;
    rst_d = (hold_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      int_q  <= 1'b0;
      nmi_q  <= 1'b0;
      rst_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      ovf_q  <= ovf_d;
      int_q  <= int_d;
      nmi_q  <= nmi_d;
      rst_q  <= rst_d;
      hold_q <= hold_d;
    end
  end

  assign ovf     = ovf_q;
  assign int_req = int_q;
  assign nmi_req = nmi_q;
  assign rst_req = rst_q;

endmodule

// File: rtl/guard_timer.sv
`timescale 1ns/1ps
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int PRE_W    = 8,
  parameter int RST_HOLD = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_in,
  input  logic       kick,
  input  logic       cfg_we,
  input  logic       cfg_run,
  input  logic [1:0] cfg_mode,
  input  logic [2:0] cfg_tap,
  output logic       ovf,
  output logic       int_req,
  output logic       nmi_req,
  output logic       rst_req
);

  logic [1:0]       sync_q;
  logic             core_rst_n;
  gt_cfg_t          wr_cfg, cfg_q;
  logic             lock_q, accept;
  logic             clear, step, wrap;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       mode_cur;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign core_rst_n = sync_q[1];

  assign wr_cfg   = '{run: cfg_run, mode: gt_mode_e'(cfg_mode), tap: cfg_tap};
  assign clear    = kick | accept | rst_req;
  assign mode_cur = cfg_q.mode;

  guard_cfg u_cfg (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .wr_en  (cfg_we),
    .wr_cfg (wr_cfg),
    .cfg    (cfg_q),
    .locked (lock_q),
    .accept (accept)
  );

  guard_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (core_rst_n),
    .tick  (tick_in),
    .run   (cfg_q.run),
    .clear (clear),
    .tap   (cfg_q.tap),
    .step  (step)
  );

  guard_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (core_rst_n),
    .step  (step),
    .clear (clear),
    .cnt   (cnt_q),
    .wrap  (wrap)
  );

  guard_action #(.RST_HOLD(RST_HOLD)) u_act (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wrap    (wrap),
    .mode    (cfg_q.mode),
    .ovf     (ovf),
    .int_req (int_req),
    .nmi_req (nmi_req),
    .rst_req (rst_req)
  );

endmodule

// File: rtl/guard_timer_chk.sv
`timescale 1ns/1ps
module guard_timer_chk #(
  parameter int CNT_W    = 8,
  parameter int RST_HOLD = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ovf,
  input logic             int_req,
  input logic             nmi_req,
  input logic             rst_req,
  input logic             cfg_we,
  input logic             locked,
  input logic [1:0]       mode_cur,
  input logic [CNT_W-1:0] cnt
);

  logic [15:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_len <= '0;
    else if (rst_req) hi_len <= (hi_len == 16'hFFFF) ? hi_len : hi_len + 1'b1;
    else              hi_len <= '0;
  end

  p_ovf_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !ovf);

  p_int_with_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ovf && !nmi_req);

  p_nmi_with_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> ovf && !int_req);

  p_rst_starts_on_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> ovf && !int_req && !nmi_req);

  p_rst_hold_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> hi_len == 16'(RST_HOLD));

  p_cnt_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> cnt == '0);

  p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  p_lock_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && cfg_we) |=> $stable(mode_cur));

endmodule

bind guard_timer guard_timer_chk #(.CNT_W(CNT_W), .RST_HOLD(RST_HOLD)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ovf      (ovf),
  .int_req  (int_req),
  .nmi_req  (nmi_req),
  .rst_req  (rst_req),
  .cfg_we   (cfg_we),
  .locked   (lock_q),
  .mode_cur (mode_cur),
  .cnt      (cnt_q)
);

// File: tb/guard_timer_bench.sv
`timescale 1ns/1ps
module guard_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_in;
  logic       kick;
  logic       cfg_we;
  logic       cfg_run;
  logic [1:0] cfg_mode;
  logic [2:0] cfg_tap;
  logic       ovf, int_req, nmi_req, rst_req;

  int n_chk  = 0;
  int n_fail = 0;
  int tick_per = 1;
  int phase    = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  guard_timer u_guard_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_in  (tick_in),
    .kick     (kick),
    .cfg_we   (cfg_we),
    .cfg_run  (cfg_run),
    .cfg_mode (cfg_mode),
    .cfg_tap  (cfg_tap),
    .ovf      (ovf),
    .int_req  (int_req),
    .nmi_req  (nmi_req),
    .rst_req  (rst_req)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [2:0]  tap;
    logic [1:0]  per;
    logic [19:0] edges;
  } vec_t;

  // role, tap, tick spacing, edges from config write to the wrap
  localparam vec_t VECS [8] = '{
    '{2'b00, 3'd0, 2'd1, 20'd256},
    '{2'b00, 3'd1, 2'd1, 20'd512},
    '{2'b01, 3'd2, 2'd1, 20'd1024},
    '{2'b00, 3'd3, 2'd2, 20'd4096},
    '{2'b10, 3'd4, 2'd1, 20'd4096},
    '{2'b10, 3'd5, 2'd1, 20'd8192},
    '{2'b11, 3'd6, 2'd1, 20'd16384},
    '{2'b00, 3'd7, 2'd1, 20'd65536}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock edge; inputs already driven, outputs sampled after return.
  task automatic clk_once();
    tick_in = (tick_per == 1) || ((phase % tick_per) == tick_per - 1);
    @(posedge clk);
    @(negedge clk);
    phase++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; kick = 1'b0; cfg_we = 1'b0; tick_in = 1'b0;
    cfg_run = 1'b0; cfg_mode = 2'b00; cfg_tap = 3'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic apply_cfg(input logic run, input logic [1:0] mode, input logic [2:0] tap);
    cfg_we = 1'b1; cfg_run = run; cfg_mode = mode; cfg_tap = tap;
    clk_once();
    cfg_we = 1'b0;
    phase = 0;
  endtask

  task automatic wait_ovf(input int limit, output int n);
    n = 0;
    for (int i = 0; i < limit; i++) begin
      clk_once();
      n++;
      if (ovf) break;
    end
    if (!ovf) n = -1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    int hi;
    rst_n = 1'b0; kick = 1'b0; cfg_we = 1'b0; tick_in = 1'b0;
    cfg_run = 1'b0; cfg_mode = 2'b00; cfg_tap = 3'd0;

    // R1: reset state and idle before any enabling write
    do_reset();
    chk("R1 outputs after reset", {ovf, int_req, nmi_req, rst_req}, 0);
    tick_per = 1;
    hi = 0;
    for (int i = 0; i < 600; i++) begin
      clk_once();
      if (ovf) hi++;
    end
    chk("R1 no wrap without enable", hi, 0);

    // Table: R2 R3 R4 count length, R5 R6 R7 request line
    for (int v = 0; v < 8; v++) begin
      do_reset();
      tick_per = int'(VECS[v].per);
      apply_cfg(1'b1, VECS[v].mode, VECS[v].tap);
      wait_ovf(int'(VECS[v].edges) + 16, n);
      chk($sformatf("R2/R3/R4 edges to wrap vec %0d", v), n, int'(VECS[v].edges));
      chk($sformatf("R5 int_req vec %0d", v), int_req, !VECS[v].mode[1]);
      chk($sformatf("R6 nmi_req vec %0d", v), nmi_req, VECS[v].mode == 2'b10);
      chk($sformatf("R7 rst_req vec %0d", v), rst_req, VECS[v].mode == 2'b11);
    end
    tick_per = 1;

    // R7 R8: reset role hold length and frozen count
    do_reset();
    apply_cfg(1'b1, 2'b11, 3'd0);
    wait_ovf(300, n);
    chk("R7 first wrap at tap 0", n, 256);
    hi = 0;
    n = 0;
    while (rst_req && n < 20) begin
      hi++;
      if (int_req || nmi_req) hi = 100;
      clk_once();
      n++;
    end
    chk("R7 rst_req hold cycles", hi, 4);
    wait_ovf(400, n);
    chk("R8 edges from wrap to next wrap", n + hi, 260);

    // R9: kick clears the prescaler phase at a divided tap
    do_reset();
    apply_cfg(1'b1, 2'b00, 3'd3);
    repeat (100) clk_once();
    kick = 1'b1;
    clk_once();
    kick = 1'b0;
    wait_ovf(2200, n);
    chk("R9 edges after mid-count kick", n, 2048);

    // R9: kick on the wrapping edge wins
    do_reset();
    apply_cfg(1'b1, 2'b10, 3'd0);
    repeat (255) clk_once();
    kick = 1'b1;
    clk_once();
    kick = 1'b0;
    chk("R9 no wrap on kick edge", {ovf, nmi_req}, 0);
    wait_ovf(300, n);
    chk("R9 edges after edge kick", n, 256);

    // R10: accepted rewrite restarts count
    do_reset();
    apply_cfg(1'b1, 2'b00, 3'd0);
    repeat (200) clk_once();
    apply_cfg(1'b1, 2'b00, 3'd0);
    wait_ovf(300, n);
    chk("R10 edges after rewrite", n, 256);

    // R11: locked write has no effect on role, tap or count
    do_reset();
    apply_cfg(1'b1, 2'b10, 3'd0);
    repeat (99) clk_once();
    cfg_we = 1'b1; cfg_run = 1'b1; cfg_mode = 2'b00; cfg_tap = 3'd3;
    clk_once();
    cfg_we = 1'b0;
    wait_ovf(300, n);
    chk("R11 edges unaffected by locked write", n + 100, 256);
    chk("R11 role still nmi", {int_req, nmi_req}, 2'b01);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule